// File: doc/BRIEF.md
# Unsigned Variable-Length Integer Byte Encoder

This block turns a fixed-width unsigned integer into a variable-length string of bytes. Each byte carries seven bits of the value in its low bits. Its top bit says whether another byte follows. A value is taken in over a valid/ready handshake and held internally. It then leaves, lowest seven-bit slice first, as a byte-wide valid/ready stream. The final byte is marked with a last flag.

The encoder sends only as many bytes as the value needs. Output stops at the first byte after which the remaining high-order bits are all zero, so small values cost a single byte. The block holds one value at a time. It does not take the next value until the final byte of the current one has been accepted downstream.

Top module: `varint_byte_encoder`

## Requirements
- R1: Byte k of an encoding carries value bits [7k+6:7k] in its bits [6:0], with k counting from 0 at the first byte, so slices leave in order of rising significance.
- R2: Bit 7 of a byte is 1 when another byte of the same value follows and 0 on the final byte. `out_last` is high exactly on the byte whose bit 7 is 0.
- R3: The number of bytes for a value equals the number of seven-bit slices up to and including its highest nonzero slice. When a value takes more than one byte, the final byte's bits [6:0] are nonzero.
- R4: A value of zero is sent as the single byte 0x00 with `out_last` high.
- R5: With the default 64-bit width, a value with bit 63 set takes ten bytes, and the tenth byte is 0x01.
- R6: `in_ready` is low from the cycle after a value is accepted until the cycle after its final byte transfers, and it is low whenever `out_valid` is high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_last` keep their values into the next cycle.
- R8: While `rst_n` is low, `out_valid` and `in_ready` are low, and the held value is discarded. `in_ready` returns high within three cycles after `rst_n` is released.
- R9: Changes on `in_data` and `in_valid` while a value is being sent do not alter the bytes of that value.
- R10: `out_valid` is high in the cycle that follows the acceptance of a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Encoder can take a value |
| in_data | input | VAL_W | Unsigned value to encode |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Continuation bit and seven-bit slice |
| out_last | output | 1 | Final byte of the current value |

## Verification
A corrupted shift register shows up at once as a wrong slice, or a wrong continuation bit, in the next byte that transfers. A stuck or miscleared busy state shows as either an extra byte after a byte whose bit 7 is clear, or a missing one, and it also shows as `in_ready` rising too early or never. Both faults are seen no later than the final byte of the value in flight. Random downstream stalls check that a held byte does not change before it is taken. Values right at the slice boundaries (127, 128, 2^56, bit 63 set) check that the length rule is exact.

// File: rtl/varint_pkg.sv
package varint_pkg;

  localparam int unsigned GRP_W = 7;

  typedef struct packed {
    logic       cont;
    logic [GRP_W-1:0] grp;
  } vbyte_t;

  function automatic int unsigned max_bytes(input int unsigned w);
    return (w + GRP_W - 1) / GRP_W;
  endfunction

endpackage

// File: rtl/varint_rst_sync.sv
module varint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/varint_slicer.sv
module varint_slicer
  import varint_pkg::*;
#(
  parameter int unsigned VAL_W = 64
) (
  input  logic [VAL_W-1:0] rem,
  output vbyte_t           vb
);

  generate
    if (VAL_W > GRP_W) begin : g_wide
      assign vb.grp  = rem[GRP_W-1:0];
      assign vb.cont = |rem[VAL_W-1:GRP_W];
    end else begin : g_narrow
      assign vb.grp  = GRP_W'(rem);
      assign vb.cont = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/varint_core.sv
module varint_core
  import varint_pkg::*;
#(
  parameter int unsigned VAL_W = 64
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             in_fire,
  input  logic [VAL_W-1:0] in_data,
  input  logic             out_fire,
  input  logic             out_is_last,
  output logic             busy,
  output logic [VAL_W-1:0] rem
);

  logic             busy_q, busy_d;
  logic [VAL_W-1:0] rem_q, rem_d;
  logic             rem_en;

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    rem_en = 1'b0;
    if (!busy_q) begin
      if (in_fire) begin
        busy_d = 1'b1;
        rem_d  = in_data;
        rem_en = 1'b1;
      end
    end else if (out_fire) begin
      if (out_is_last) begin
        busy_d = 1'b0;
      end else begin
        rem_d  = rem_q >> GRP_W;
        rem_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (rem_en) begin
        rem_q <= rem_d;
      end
    end
  end

  assign busy = busy_q;
  assign rem  = rem_q;

endmodule

// File: rtl/varint_byte_encoder.sv
module varint_byte_encoder
  import varint_pkg::*;
#(
  parameter int unsigned VAL_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VAL_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             out_last
);

  logic             srst_n;
  logic             busy;
  logic [VAL_W-1:0] rem;
  vbyte_t           vb;
  logic             in_fire;
  logic             out_fire;

  varint_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  varint_slicer #(.VAL_W(VAL_W)) u_slice (
    .rem (rem),
    .vb  (vb)
  );

  assign in_ready = srst_n & ~busy;
  assign in_fire  = in_valid & in_ready;
  assign out_fire = busy & out_ready;

  varint_core #(.VAL_W(VAL_W)) u_core (
    .clk         (clk),
    .srst_n      (srst_n),
    .in_fire     (in_fire),
    .in_data     (in_data),
    .out_fire    (out_fire),
    .out_is_last (~vb.cont),
    .busy        (busy),
    .rem         (rem)
  );

  assign out_valid = busy;
  assign out_byte  = vb;
  assign out_last  = ~vb.cont;

endmodule

// File: rtl/varint_byte_encoder_chk.sv
module varint_byte_encoder_chk
  import varint_pkg::*;
#(
  parameter int unsigned VAL_W = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_last
);

  localparam int unsigned MAXB = max_bytes(VAL_W);
  localparam int unsigned CW   = $clog2(MAXB + 1);
  localparam logic [CW-1:0] LIM = CW'(MAXB);

  logic [CW-1:0] sent_q;
  logic          rst_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
    end else if (out_valid && out_ready) begin
      sent_q <= out_last ? '0 : sent_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    rst_seen_q <= !rst_n;
  end

  // R8: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n && rst_seen_q) begin
      a_r8_reset_quiet: assert (!out_valid && !in_ready);
    end
  end

  // R2
  a_r2_last_matches_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == !out_byte[7]));

  // R3
  a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sent_q < LIM));

  // R3
  a_r3_no_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && sent_q != '0) |-> (out_byte[6:0] != 7'd0));

  // R6
  a_r6_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R7
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

  // R10
  a_r10_accept_starts_output: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

endmodule

bind varint_byte_encoder varint_byte_encoder_chk #(.VAL_W(VAL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_byte  (out_byte),
  .out_last  (out_last)
);

// File: tb/sim_varint_byte_encoder.sv
module sim_varint_byte_encoder;

  localparam int VW = 64;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [VW-1:0] in_data;
  logic          out_valid;
  logic          out_ready;
  logic [7:0]    out_byte;
  logic          out_last;

  varint_byte_encoder #(.VAL_W(VW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_last  (out_last)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int         checks = 0;
  int         fails  = 0;
  int         xfer_cnt = 0;
  int         rdy_mode = 0;
  logic [8:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;
  logic [63:0] rnd  = 64'h9E37_79B9_7F4A_7C15;
  bit         hold_pend = 0;
  logic [7:0] hold_b;
  logic       hold_l;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0] | lfsr[3];
      default: out_ready = 1'b0;
    endcase
    if (!rst_n) begin
      hold_pend = 0;
    end else begin
      if (out_valid) chk(!in_ready, "R6", "in_ready while sending", 64'(in_ready), 0);
      if (hold_pend)
        chk(out_valid && out_byte == hold_b && out_last == hold_l, "R7",
            "held byte changed", {out_valid, out_last, out_byte}, {1'b1, hold_l, hold_b});
      hold_pend = out_valid && !out_ready;
      hold_b = out_byte;
      hold_l = out_last;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected extra byte", 64'(out_byte), 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(out_byte == e[7:0], "R1", "byte value", 64'(out_byte), 64'(e[7:0]));
          chk(out_last == e[8], "R2", "last flag", 64'(out_last), 64'(e[8]));
          xfer_cnt++;
        end
      end
    end
  end

  function automatic logic [63:0] step_rnd(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic send(input logic [VW-1:0] v, input bit junk, input string tag);
    logic [VW-1:0] t;
    int n;
    int start;
    t = v;
    n = 0;
    do begin
      logic [6:0] g;
      g = t[6:0];
      t = t >> 7;
      exp_q.push_back({(t == 0), (t != 0), g});
      n++;
    end while (t != 0);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    start = xfer_cnt;
    in_valid = 1'b1;
    in_data  = v;
    @(negedge clk);
    chk(out_valid && !in_ready, "R10", "output after accept", {in_ready, out_valid}, 2'b01);
    if (!junk) in_valid = 1'b0;
    while (!in_ready) begin
      if (junk) begin
        rnd = step_rnd(rnd);
        in_data = rnd;
        in_valid = rnd[5];
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(xfer_cnt - start == n, tag, "byte count", 64'(xfer_cnt - start), 64'(n));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    out_ready = 1'b1;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!out_valid && !in_ready, "R8", "outputs in reset", {in_ready, out_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid, "R8", "ready after release", {in_ready, out_valid}, 2'b10);

    send(64'd0, 0, "R4");
    send(64'd1, 0, "R3");
    send(64'd127, 0, "R3");
    send(64'd128, 0, "R3");
    send(64'd300, 1, "R9");
    send(64'h3FFF, 0, "R3");
    send(64'h4000, 0, "R3");
    send(64'h00FF_FFFF_FFFF_FFFF, 0, "R3");
    send(64'h0100_0000_0000_0000, 0, "R3");
    send(64'h8000_0000_0000_0000, 0, "R5");
    send(64'hFFFF_FFFF_FFFF_FFFF, 1, "R5");

    rdy_mode = 1;
    send(64'd0, 1, "R4");
    send(64'hFFFF_FFFF_FFFF_FFFF, 0, "R5");
    for (int i = 0; i < 60; i++) begin
      logic [63:0] v;
      rnd = step_rnd(rnd);
      v = rnd >> rnd[5:0];
      rnd = step_rnd(rnd);
      send(v, rnd[0], rnd[0] ? "R9" : "R3");
    end

    // reset while a value is stalled
    rdy_mode = 2;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data = 64'd300;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid, "R7", "stalled byte present", 64'(out_valid), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && !in_ready, "R8", "reset drops output", {in_ready, out_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    rdy_mode = 0;
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid, "R8", "idle after reset", {in_ready, out_valid}, 2'b10);
    send(64'd150, 0, "R3");

    chk(exp_q.size() == 0, "R3", "bytes left unsent", 64'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule